// File: doc/BRIEF.md
# DMA Remapping Fault Recorder

This block sits beside an address-remapping unit and keeps a record of the translation faults that unit reports. Each report carries a requester ID, a faulting address and a reason code. The block stores the report in one of a small, fixed set of recording slots, keeps a status word whose bits are set by hardware and cleared by software writing one, and produces a fault event interrupt.

An optional advanced in-memory log is modelled only by its write index and its overflow. No memory traffic is generated. The index advances on every report until the configured depth is reached.

Software reaches the block through a plain word-addressed register port. A read is requested with `reg_rd`, and the data appears on `reg_rdata` from the next clock edge onward. Interrupt masking and a sticky pending bit live in an event control register. The current mask is also driven out as a pin.

Top module: `dma_fault_recorder`

## Requirements
- R1: After reset the status word (address 0x00) reads 0, the event control word (0x01) reads 1 (masked, nothing pending), the advanced index (0x02) reads 0 and `evt_irq` is low.
- R2: An accepted report goes into the first slot whose F flag is clear, scanning from an allocation pointer and wrapping. The pointer is 0 after reset and then points one past the slot last filled. Slot s is read one cycle after `reg_rd` at 0x10+4s+k:
  - k=0 gives the requester ID.
  - k=1 gives address bits 31:0, with bits 11:0 reading zero.
  - k=2 gives address bits 63:32.
  - k=3 gives the F flag in bit 31 and the reason in bits 7:0.
- R3: Status bit 1 (primary pending) is live: it is the OR of all slot F flags. Writing 1 to bit 31 of a slot's word 3 clears that slot's F flag.
- R4: Status bits 15:8 (record index) load the number of the filled slot only on a report that takes primary pending from 0 to 1. Otherwise they hold.
- R5: Status bit 0 (primary overflow) sets when a report finds no free slot. While it is set, reports set no F flag and change no record. Writing 1 to bit 0 clears it.
- R6: Status bit 3 (advanced pending) sets when an advanced record is written at index 0 while the bit is clear. Writing 1 to bit 3 clears it.
- R7: Each report writes an advanced record at the index held in 0x02 bits 7:0 and increments that index, provided the index is below the log depth (default 4). A report that arrives when the index equals the depth sets status bit 2 (advanced overflow). Writing 1 to bit 2 clears status bit 2. Writing 1 to bit 0 of 0x02 returns the index to 0.
- R8: A fault event is any of the following: primary pending rising, advanced pending being set, or advanced overflow being set. With the mask clear, a fault event drives `evt_irq` high for exactly the cycle after the report's clock edge. Primary overflow alone raises no event.
- R9: In word 0x01, bit 0 is the mask and bit 1 is a read-only pending bit. A masked event sets the pending bit and leaves `evt_irq` low. Writing 0 to the mask while pending is set drives `evt_irq` high for one cycle and clears the pending bit.
- R10: Writing 0 to any status bit changes nothing. A write to status bit 1 is ignored.
- R11: With the advanced log disabled by parameter, status bits 2 and 3 always read 0, while the primary bits behave as with the log enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flt_valid | input | 1 | Fault report strobe, one cycle per report |
| flt_rid | input | 16 | Requester ID of the report |
| flt_addr | input | 64 | Faulting address (page offset discarded) |
| flt_reason | input | 8 | Fault reason code |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Word address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| evt_irq | output | 1 | One-cycle fault event interrupt pulse |
| evt_mask | output | 1 | Current interrupt mask |

## Verification
Two behaviours get the most attention. The first is allocation wrapping past the top slot. The second is record-index capture: a design that scans from slot 0, or reloads the index on every report, reports the wrong slot number. Overflow is driven with every slot full and then with one slot freed while overflow is still set; a design that keeps accepting reports overwrites an older record, which the bench reads back. The mask path is checked in both directions. A design that loses the pending bit, or fires on every unmask, shows a missing or extra `evt_irq` pulse. Zero writes and writes to the read-only pending bit must leave the status word unchanged, and a second instance without the advanced log must keep its advanced bits at zero.

// File: rtl/dfr_pkg.sv
package dfr_pkg;
  localparam logic [7:0] REG_STATUS    = 8'h00;
  localparam logic [7:0] REG_EVT       = 8'h01;
  localparam logic [7:0] REG_ADV       = 8'h02;
  localparam logic [7:0] REG_SLOT_BASE = 8'h10;

  // status bit positions
  localparam int ST_PFO = 0;
  localparam int ST_PPF = 1;
  localparam int ST_AFO = 2;
  localparam int ST_APF = 3;

  // slot word selectors
  localparam logic [1:0] SW_RID  = 2'd0;
  localparam logic [1:0] SW_ALO  = 2'd1;
  localparam logic [1:0] SW_AHI  = 2'd2;
  localparam logic [1:0] SW_CTRL = 2'd3;
endpackage

// File: rtl/dfr_slot_alloc.sv
module dfr_slot_alloc #(
  parameter int NUM_SLOTS = 8,
  localparam int IDX_W = $clog2(NUM_SLOTS)
) (
  input  logic [NUM_SLOTS-1:0] busy,
  input  logic [IDX_W-1:0]     start,
  output logic                 found,
  output logic [IDX_W-1:0]     slot
);
  // Scan offsets from the highest down so the smallest offset wins.
  always_comb begin
    found = 1'b0;
    slot  = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      int cand;
      cand = int'(start) + i;
      if (cand >= NUM_SLOTS) cand = cand - NUM_SLOTS;
      if (!busy[cand]) begin
        found = 1'b1;
        slot  = IDX_W'(cand);
      end
    end
  end
endmodule

// File: rtl/dfr_record_store.sv
module dfr_record_store #(
  parameter int NUM_SLOTS = 8,
  parameter int RID_W     = 16,
  parameter int PA_W      = 52,
  parameter int RSN_W     = 8,
  localparam int IDX_W = $clog2(NUM_SLOTS)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [RID_W-1:0] wrid,
  input  logic [PA_W-1:0]  wpa,
  input  logic [RSN_W-1:0] wrsn,
  input  logic [IDX_W-1:0] raddr,
  output logic [RID_W-1:0] rrid,
  output logic [PA_W-1:0]  rpa,
  output logic [RSN_W-1:0] rrsn
);
  localparam int REC_W = RID_W + PA_W + RSN_W;

  logic [REC_W-1:0] mem [NUM_SLOTS];
  logic [REC_W-1:0] rd_word;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= {wrid, wpa, wrsn};
  end

  assign rd_word = mem[raddr];
  assign rrid    = rd_word[REC_W-1 -: RID_W];
  assign rpa     = rd_word[RSN_W +: PA_W];
  assign rrsn    = rd_word[RSN_W-1:0];
endmodule

// File: rtl/dfr_event_ctrl.sv
module dfr_event_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic ev,
  input  logic mask_wr,
  input  logic mask_wd,
  output logic mask_q,
  output logic pend_q,
  output logic irq
);
  logic mask_eff;
  assign mask_eff = mask_wr ? mask_wd : mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= 1'b1;
      pend_q <= 1'b0;
      irq    <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (mask_wr) begin
        mask_q <= mask_wd;
        if (!mask_wd && pend_q) begin
          irq    <= 1'b1;
          pend_q <= 1'b0;
        end
      end
      if (ev) begin
        if (mask_eff) pend_q <= 1'b1;
        else          irq    <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_fault_recorder.sv
module dma_fault_recorder
  import dfr_pkg::*;
#(
  parameter int NUM_SLOTS  = 8,
  parameter int RID_W      = 16,
  parameter int ADDR_W     = 64,
  parameter int RSN_W      = 8,
  parameter int PAGE_SHIFT = 12,
  parameter int REG_AW     = 8,
  parameter bit ADV_LOG_EN = 1'b1,
  parameter int ADV_DEPTH  = 4,
  localparam int IDX_W     = $clog2(NUM_SLOTS),
  localparam int PA_W      = ADDR_W - PAGE_SHIFT,
  localparam int ADV_IDX_W = $clog2(ADV_DEPTH + 1),
  localparam int SLOT_SPAN = 4 * NUM_SLOTS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flt_valid,
  input  logic [RID_W-1:0]  flt_rid,
  input  logic [ADDR_W-1:0] flt_addr,
  input  logic [RSN_W-1:0]  flt_reason,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              evt_irq,
  output logic              evt_mask
);
  logic [NUM_SLOTS-1:0] f_q, f_clr, f_set, f_next;
  logic [IDX_W-1:0]     ptr_q, fri_q, alloc_slot;
  logic                 alloc_found;
  logic                 pfo_q, apf_q, afo_q;
  logic [ADV_IDX_W-1:0] adv_idx_q;
  logic                 ppf, ppf_rise, apf_set, afo_set, fault_ev;
  logic                 accept, no_room;
  logic                 wr_status, wr_evt, wr_adv;
  logic                 slot_hit;
  logic [REG_AW-1:0]    slot_off;
  logic [IDX_W-1:0]     rd_slot;
  logic [1:0]           rd_word;
  logic [RID_W-1:0]     rd_rid;
  logic [PA_W-1:0]      rd_pa;
  logic [RSN_W-1:0]     rd_rsn;
  logic [63:0]          rd_addr64;
  logic [31:0]          rd_mux;
  logic                 pend_q;
  logic                 unused_bits;

  assign unused_bits = ^{flt_addr[PAGE_SHIFT-1:0], reg_wdata};

  // register decode
  assign wr_status = reg_wr && (reg_addr == REG_AW'(REG_STATUS));
  assign wr_evt    = reg_wr && (reg_addr == REG_AW'(REG_EVT));
  assign wr_adv    = reg_wr && (reg_addr == REG_AW'(REG_ADV));
  assign slot_off  = reg_addr - REG_AW'(REG_SLOT_BASE);
  assign slot_hit  = (reg_addr >= REG_AW'(REG_SLOT_BASE)) && (int'(slot_off) < SLOT_SPAN);
  assign rd_slot   = IDX_W'(slot_off >> 2);
  assign rd_word   = slot_off[1:0];

  // slot allocation
  dfr_slot_alloc #(.NUM_SLOTS(NUM_SLOTS)) u_alloc (
    .busy  (f_q),
    .start (ptr_q),
    .found (alloc_found),
    .slot  (alloc_slot)
  );

  assign accept  = flt_valid && !pfo_q && alloc_found;
  assign no_room = flt_valid && !pfo_q && !alloc_found;

  always_comb begin
    f_clr = '0;
    f_set = '0;
    if (reg_wr && slot_hit && rd_word == SW_CTRL && reg_wdata[31]) f_clr[rd_slot] = 1'b1;
    if (accept) f_set[alloc_slot] = 1'b1;
  end

  assign f_next   = (f_q & ~f_clr) | f_set;
  assign ppf      = |f_q;
  assign ppf_rise = !ppf && (|f_next);

  always_ff @(posedge clk) begin
    if (rst) begin
      f_q   <= '0;
      ptr_q <= '0;
      fri_q <= '0;
      pfo_q <= 1'b0;
    end else begin
      f_q <= f_next;
      if (accept) begin
        ptr_q <= (int'(alloc_slot) == NUM_SLOTS - 1) ? '0 : alloc_slot + 1'b1;
      end
      if (ppf_rise) fri_q <= alloc_slot;
      if (no_room) pfo_q <= 1'b1;
      else if (wr_status && reg_wdata[ST_PFO]) pfo_q <= 1'b0;
    end
  end

  // record storage
  dfr_record_store #(
    .NUM_SLOTS (NUM_SLOTS),
    .RID_W     (RID_W),
    .PA_W      (PA_W),
    .RSN_W     (RSN_W)
  ) u_store (
    .clk   (clk),
    .we    (accept),
    .waddr (alloc_slot),
    .wrid  (flt_rid),
    .wpa   (flt_addr[ADDR_W-1:PAGE_SHIFT]),
    .wrsn  (flt_reason),
    .raddr (rd_slot),
    .rrid  (rd_rid),
    .rpa   (rd_pa),
    .rrsn  (rd_rsn)
  );

  // advanced log: index and overflow only
  generate
    if (ADV_LOG_EN) begin : g_adv
      logic adv_write, adv_full;
      assign adv_full  = (int'(adv_idx_q) == ADV_DEPTH);
      assign adv_write = flt_valid && !adv_full;
      assign apf_set   = adv_write && (adv_idx_q == '0) && !apf_q;
      assign afo_set   = flt_valid && adv_full && !afo_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          adv_idx_q <= '0;
          apf_q     <= 1'b0;
          afo_q     <= 1'b0;
        end else begin
          if (wr_adv && reg_wdata[0]) adv_idx_q <= '0;
          else if (adv_write)         adv_idx_q <= adv_idx_q + 1'b1;
          if (apf_set) apf_q <= 1'b1;
          else if (wr_status && reg_wdata[ST_APF]) apf_q <= 1'b0;
          if (afo_set) afo_q <= 1'b1;
          else if (wr_status && reg_wdata[ST_AFO]) afo_q <= 1'b0;
        end
      end
    end else begin : g_no_adv
      assign adv_idx_q = '0;
      assign apf_q     = 1'b0;
      assign afo_q     = 1'b0;
      assign apf_set   = 1'b0;
      assign afo_set   = 1'b0;
    end
  endgenerate

  // fault event and interrupt
  assign fault_ev = ppf_rise || apf_set || afo_set;

  dfr_event_ctrl u_evt (
    .clk     (clk),
    .rst     (rst),
    .ev      (fault_ev),
    .mask_wr (wr_evt),
    .mask_wd (reg_wdata[0]),
    .mask_q  (evt_mask),
    .pend_q  (pend_q),
    .irq     (evt_irq)
  );

  // read path
  assign rd_addr64 = 64'({rd_pa, {PAGE_SHIFT{1'b0}}});

  always_comb begin
    rd_mux = '0;
    if (reg_addr == REG_AW'(REG_STATUS)) begin
      rd_mux[ST_PFO] = pfo_q;
      rd_mux[ST_PPF] = ppf;
      rd_mux[ST_AFO] = afo_q;
      rd_mux[ST_APF] = apf_q;
      rd_mux[15:8]   = 8'(fri_q);
    end else if (reg_addr == REG_AW'(REG_EVT)) begin
      rd_mux[1:0] = {pend_q, evt_mask};
    end else if (reg_addr == REG_AW'(REG_ADV)) begin
      rd_mux[7:0] = 8'(adv_idx_q);
    end else if (slot_hit) begin
      case (rd_word)
        SW_RID:  rd_mux = 32'(rd_rid);
        SW_ALO:  rd_mux = rd_addr64[31:0];
        SW_AHI:  rd_mux = rd_addr64[63:32];
        default: rd_mux = {f_q[rd_slot], 23'b0, 8'(rd_rsn)};
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/dfr_checker.sv
module dfr_checker
  import dfr_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int ADV_IDX_W = 3,
  parameter int REG_AW    = 8,
  localparam int IDX_W = $clog2(NUM_SLOTS)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 flt_valid,
  input logic [NUM_SLOTS-1:0] f_q,
  input logic [IDX_W-1:0]     fri_q,
  input logic                 pfo_q,
  input logic                 apf_q,
  input logic [ADV_IDX_W-1:0] adv_idx_q,
  input logic                 evt_mask,
  input logic                 evt_irq,
  input logic                 reg_wr,
  input logic [REG_AW-1:0]    reg_addr
);
  // R5: while overflow is set, no report fills a slot
  assert_drop_on_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    (pfo_q && flt_valid) |=> ((f_q & ~$past(f_q)) == '0));

  // R5: overflow only rises when every slot was occupied
  assert_overflow_needs_full_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(pfo_q) |-> $past(&f_q));

  // R4: when pending rises, the index names an occupied slot
  assert_index_on_rise_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(|f_q) |-> f_q[fri_q]);

  // R9: a masked block stays silent unless software writes the control word
  assert_masked_silent_R9: assert property (@(posedge clk) disable iff (rst)
    (evt_mask && !(reg_wr && reg_addr == REG_AW'(REG_EVT))) |=> !evt_irq);

  // R6: advanced pending only rises on the record at index 0
  assert_apf_first_record_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(apf_q) |-> ($past(adv_idx_q) == '0));
endmodule

bind dma_fault_recorder dfr_checker #(
  .NUM_SLOTS (NUM_SLOTS),
  .ADV_IDX_W (ADV_IDX_W),
  .REG_AW    (REG_AW)
) u_dfr_checker (
  .clk       (clk),
  .rst       (rst),
  .flt_valid (flt_valid),
  .f_q       (f_q),
  .fri_q     (fri_q),
  .pfo_q     (pfo_q),
  .apf_q     (apf_q),
  .adv_idx_q (adv_idx_q),
  .evt_mask  (evt_mask),
  .evt_irq   (evt_irq),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr)
);

// File: tb/test_dma_fault_recorder.sv
`timescale 1ns/1ps
module test_dma_fault_recorder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flt_valid = 1'b0;
  logic [15:0] flt_rid = '0;
  logic [63:0] flt_addr = '0;
  logic [7:0]  flt_reason = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata, rdata_b;
  logic        evt_irq, evt_mask, irq_b, mask_b;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dma_fault_recorder i_dma_fault_recorder (
    .clk(clk), .rst(rst), .flt_valid(flt_valid), .flt_rid(flt_rid),
    .flt_addr(flt_addr), .flt_reason(flt_reason), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .evt_irq(evt_irq), .evt_mask(evt_mask)
  );

  // second copy without the advanced log (R11)
  dma_fault_recorder #(.ADV_LOG_EN(1'b0)) i_dma_fault_recorder_noadv (
    .clk(clk), .rst(rst), .flt_valid(flt_valid), .flt_rid(flt_rid),
    .flt_addr(flt_addr), .flt_reason(flt_reason), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(rdata_b), .evt_irq(irq_b), .evt_mask(mask_b)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_fault(input logic [15:0] rid);
    @(negedge clk);
    flt_valid  = 1'b1;
    flt_rid    = rid;
    flt_addr   = {16'hCAFE, rid, rid, rid};
    flt_reason = rid[7:0];
    @(negedge clk);
    flt_valid  = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  // reads both copies; the status word of the copy without the log must have bits 3:2 clear (R11)
  task automatic do_read(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    chk(req, reg_rdata, exp);
    if (a == 8'h00) chk("R11 status without log", rdata_b, exp & ~32'hC);
  endtask

  // op: 1 write, 2 read, 3 fault report (data = requester ID)
  localparam int NV = 32;
  localparam logic [79:0] VEC [NV] = '{
    {4'd2, 4'd1,  8'h00, 32'h0,        32'h0},        // R1 status after reset
    {4'd2, 4'd1,  8'h01, 32'h0,        32'h1},        // R1 masked, nothing pending
    {4'd3, 4'd2,  8'h00, 32'h0101,     32'h0},        // -> slot 0, pending rises, adv index 0
    {4'd2, 4'd3,  8'h00, 32'h0,        32'h0000000A}, // R3 R6 pending and adv pending
    {4'd2, 4'd9,  8'h01, 32'h0,        32'h3},        // R9 masked event went to pending
    {4'd2, 4'd2,  8'h10, 32'h0,        32'h00000101}, // R2 requester ID
    {4'd2, 4'd2,  8'h11, 32'h0,        32'h01010000}, // R2 address low, page offset zero
    {4'd2, 4'd2,  8'h12, 32'h0,        32'hCAFE0101}, // R2 address high
    {4'd2, 4'd2,  8'h13, 32'h0,        32'h80000001}, // R2 F flag and reason
    {4'd1, 4'd10, 8'h00, 32'h0,        32'h0},        // R10 zero write
    {4'd2, 4'd10, 8'h00, 32'h0,        32'h0000000A}, // R10 unchanged
    {4'd3, 4'd2,  8'h00, 32'h0202,     32'h0},        // -> slot 1
    {4'd1, 4'd6,  8'h00, 32'h8,        32'h0},        // R6 clear adv pending
    {4'd2, 4'd6,  8'h00, 32'h0,        32'h2},
    {4'd1, 4'd3,  8'h13, 32'h80000000, 32'h0},        // R3 clear F of slot 0
    {4'd2, 4'd3,  8'h13, 32'h0,        32'h1},
    {4'd2, 4'd3,  8'h00, 32'h0,        32'h2},        // R3 slot 1 still pending
    {4'd3, 4'd2,  8'h00, 32'h0303,     32'h0},        // R2 pointer at 2 -> slot 2, not slot 0
    {4'd2, 4'd2,  8'h18, 32'h0,        32'h00000303},
    {4'd1, 4'd3,  8'h17, 32'h80000000, 32'h0},
    {4'd1, 4'd3,  8'h1B, 32'h80000000, 32'h0},
    {4'd2, 4'd3,  8'h00, 32'h0,        32'h0},        // R3 all clear, pending drops
    {4'd3, 4'd4,  8'h00, 32'h0404,     32'h0},        // -> slot 3, pending rises
    {4'd2, 4'd4,  8'h00, 32'h0,        32'h00000302}, // R4 index now 3
    {4'd2, 4'd2,  8'h1C, 32'h0,        32'h00000404},
    {4'd3, 4'd7,  8'h00, 32'h0505,     32'h0},        // -> slot 4, adv log full
    {4'd2, 4'd7,  8'h00, 32'h0,        32'h00000306}, // R7 adv overflow
    {4'd1, 4'd7,  8'h00, 32'h4,        32'h0},
    {4'd2, 4'd7,  8'h00, 32'h0,        32'h00000302}, // R7 cleared
    {4'd2, 4'd7,  8'h02, 32'h0,        32'h4},        // R7 index at depth
    {4'd1, 4'd7,  8'h02, 32'h1,        32'h0},
    {4'd2, 4'd7,  8'h02, 32'h0,        32'h0}         // R7 index reset
  };

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 irq after reset", 32'(evt_irq), 32'h0);

    for (int v = 0; v < NV; v++) begin
      string tag;
      tag = $sformatf("R%0d vector %0d", VEC[v][75:72], v);
      case (VEC[v][79:76])
        4'd1: do_write(VEC[v][71:64], VEC[v][63:32]);
        4'd2: do_read(tag, VEC[v][71:64], VEC[v][31:0]);
        default: do_fault(VEC[v][47:32]);
      endcase
    end

    // R9: unmask with pending set fires exactly once
    do_write(8'h01, 32'h0);
    chk("R9 irq on unmask", 32'(evt_irq), 32'h1);
    @(negedge clk);
    chk("R9 irq single pulse", 32'(evt_irq), 32'h0);
    do_read("R9 pending cleared", 8'h01, 32'h0);

    // R8: adv pending set while unmasked gives a pulse in the next cycle
    do_fault(16'h0606);                         // slot 5
    chk("R8 irq after event", 32'(evt_irq), 32'h1);
    @(negedge clk);
    chk("R8 irq one cycle", 32'(evt_irq), 32'h0);

    // R2: wrap past the top slot
    do_fault(16'h0707);                         // slot 6
    do_fault(16'h0808);                         // slot 7
    do_fault(16'h0909);                         // slot 0 (wrapped)
    do_fault(16'h0A0A);                         // slot 1, adv overflow
    do_fault(16'h0B0B);                         // slot 2, all full
    do_read("R2 wrap status", 8'h00, 32'h0000030E);
    do_read("R2 wrap to slot 0", 8'h10, 32'h00000909);
    do_read("R2 slot 2", 8'h18, 32'h00000B0B);

    // R5: overflow, and no event from it (R8)
    do_fault(16'h0C0C);
    chk("R8 no irq for primary overflow", 32'(evt_irq), 32'h0);
    do_read("R5 overflow set", 8'h00, 32'h0000030F);

    // R5: free one slot, report while overflow set is dropped
    do_write(8'h23, 32'h80000000);
    do_fault(16'h0D0D);
    do_read("R5 record kept", 8'h20, 32'h00000505);
    do_read("R5 slot stays free", 8'h23, 32'h00000005);

    // R5: clear overflow, next report fills slot 4
    do_write(8'h00, 32'h1);
    do_read("R5 overflow cleared", 8'h00, 32'h0000030E);
    do_fault(16'h0E0E);
    do_read("R5 accepted after clear", 8'h20, 32'h00000E0E);
    do_read("R4 index held", 8'h00, 32'h0000030E);

    // R10: write to the read-only pending bit
    do_write(8'h00, 32'h2);
    do_read("R10 pending bit read-only", 8'h00, 32'h0000030E);

    // R9: masked event then unmask
    do_write(8'h01, 32'h1);
    do_write(8'h00, 32'hC);
    do_write(8'h02, 32'h1);
    do_read("R6 R7 cleared", 8'h00, 32'h00000302);
    do_fault(16'h0F0F);
    chk("R9 masked no irq", 32'(evt_irq), 32'h0);
    do_read("R9 pending set", 8'h01, 32'h3);
    do_read("R6 set again at index 0", 8'h00, 32'h0000030B);
    do_write(8'h01, 32'h0);
    chk("R9 irq on unmask again", 32'(evt_irq), 32'h1);
    @(negedge clk);
    chk("R9 single pulse again", 32'(evt_irq), 32'h0);

    // R1: reset in mid run
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    chk("R1 irq after second reset", 32'(evt_irq), 32'h0);
    do_read("R1 status after reset", 8'h00, 32'h0);
    do_read("R1 control after reset", 8'h01, 32'h1);
    do_read("R1 adv index after reset", 8'h02, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule